// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received frame, whether it is kept or discarded, based on the frame's 48-bit destination address and its length. It holds sixteen exact-match addresses. Software loads them by sending a setup frame, which arrives as a byte stream. The setup frame is 192 bytes long and is split into sixteen 12-byte slices. Only six bytes of each slice carry address data.

A four-bit mode register selects the extra acceptance rules: promiscuous, receive-all, pass-all-multicast and inverse matching. Frames that are too short or too long are discarded before any address rule is applied. Each decision comes with two flags that the receive path stores in its status:
- a filtering-fail flag, raised when the frame was taken only because of promiscuous or receive-all mode;
- a multicast flag, raised when the frame was taken only because of pass-all-multicast.

Byte 0 of a destination address is the first byte on the wire and sits in `frm_da[7:0]`. Byte k sits in `frm_da[8k+7:8k]`.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the block is in this state:
  - all sixteen table entries hold zero, so an in-range frame addressed to 00:00:00:00:00:00 is accepted;
  - all mode bits are off;
  - `res_accept`, `res_filt_fail` and `res_mcast` are 0.
- R2: A setup frame is announced by `cfg_start`, with its length on `cfg_len` in the same cycle. The table is written only when that length is exactly 192. For any other length, the following `cfg_valid` bytes leave every entry unchanged.
- R3: Bytes arrive on `cfg_byte` with `cfg_valid`, counted from 0 after `cfg_start`. Byte i belongs to entry i/12 at slice offset i%12. Slice offsets 0, 1, 4, 5, 8 and 9 become address bytes 0 to 5 of that entry. All other offsets are discarded.
- R4: The exact-match result is true when `frm_da` equals any of the sixteen entries.
- R5: An in-range frame to FF:FF:FF:FF:FF:FF is always accepted, whatever the mode bits, and with both flags low.
- R6: Otherwise, if promiscuous mode or receive-all mode is on, the frame is accepted with `res_filt_fail` high.
- R7: Otherwise, if pass-all-multicast is on and `frm_da[0]` is 1, the frame is accepted with `res_mcast` high.
- R8: Otherwise, the decision is the exact-match result, inverted when inverse mode is on. Both flags are low in this case.
- R9: The rules are applied in a fixed priority: broadcast first, then promiscuous/receive-all, then multicast, then exact match. At most one flag is ever high, and a high flag implies acceptance.
- R10: A frame whose `frm_len` is below 14 or above 2044 is rejected with both flags low, before any address rule is applied.
- R11: The decision is registered. It appears in the cycle after `frm_valid` and stays unchanged until the next `frm_valid`.
- R12: `mode_we` loads `mode_in` into the mode register. The bit meanings are:
  - bit 0: promiscuous;
  - bit 1: receive-all;
  - bit 2: pass-all-multicast;
  - bit 3: inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Marks the start of a setup frame |
| cfg_len | input | 12 | Setup frame length in bytes, sampled with `cfg_start` |
| cfg_valid | input | 1 | A setup byte is present on `cfg_byte` |
| cfg_byte | input | 8 | Setup frame byte |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_in | input | 4 | New mode bits (see R12) |
| frm_valid | input | 1 | Evaluate the frame presented this cycle |
| frm_da | input | 48 | Destination address, byte 0 in bits 7:0 |
| frm_len | input | 12 | Frame length in bytes |
| res_accept | output | 1 | Frame accepted |
| res_filt_fail | output | 1 | Accepted only by promiscuous or receive-all mode |
| res_mcast | output | 1 | Accepted only by pass-all-multicast |

## Verification
The address decision is exercised with several kinds of destination:
- table addresses taken from the first, middle and last entries;
- an address built from the discarded slice offsets, which separates a correct byte mapping from a contiguous copy;
- unlisted unicast and multicast addresses, and the broadcast address.

Each kind of destination is presented under every mode combination that moves it to a different rule, which shows that the priority order is correct. Setup frames of legal and illegal length show that the table is updated only by a full 192-byte frame. Frame lengths at 13, 14, 2044 and 2045 pin down both edges of the length gate.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ENTRIES = 16,
  parameter int SLICE   = 12,
  parameter int LEN_W   = 12,
  parameter int MIN_LEN = 14,
  parameter int MAX_LEN = 2044
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_valid,
  input  logic [7:0]       cfg_byte,
  input  logic             mode_we,
  input  logic [3:0]       mode_in,
  input  logic             frm_valid,
  input  logic [47:0]      frm_da,
  input  logic [LEN_W-1:0] frm_len,
  output logic             res_accept,
  output logic             res_filt_fail,
  output logic             res_mcast
);
  localparam int SETUP_LEN = ENTRIES * SLICE;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int OFF_W     = $clog2(SLICE);
  localparam int M_PROM = 0, M_RALL = 1, M_MCAST = 2, M_INV = 3;

  logic [47:0]      tbl [ENTRIES];
  logic             ld_act;
  logic [IDX_W-1:0] ld_ent;
  logic [OFF_W-1:0] ld_off;
  logic [2:0]       ld_slot;
  logic             ld_use;
  logic [3:0]       mode_q;
  logic [ENTRIES-1:0] hit_vec;

  always_comb begin
    ld_use  = 1'b1;
    ld_slot = 3'd0;
    case (ld_off)
      OFF_W'(0): ld_slot = 3'd0;
      OFF_W'(1): ld_slot = 3'd1;
      OFF_W'(4): ld_slot = 3'd2;
      OFF_W'(5): ld_slot = 3'd3;
      OFF_W'(8): ld_slot = 3'd4;
      OFF_W'(9): ld_slot = 3'd5;
      default:   ld_use  = 1'b0;
    endcase
  end

  wire ld_last = (ld_ent == IDX_W'(ENTRIES - 1)) && (ld_off == OFF_W'(SLICE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_act <= 1'b0;
      ld_ent <= '0;
      ld_off <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (cfg_start) begin
      ld_act <= (cfg_len == LEN_W'(SETUP_LEN));
      ld_ent <= '0;
      ld_off <= '0;
    end else if (cfg_valid && ld_act) begin
      if (ld_use) tbl[ld_ent][ld_slot*8 +: 8] <= cfg_byte;
      if (ld_last) ld_act <= 1'b0;
      if (ld_off == OFF_W'(SLICE - 1)) begin
        ld_off <= '0;
        ld_ent <= ld_ent + 1'b1;
      end else begin
        ld_off <= ld_off + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_in;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = (tbl[g] == frm_da);
  end

  wire len_ok  = (frm_len >= LEN_W'(MIN_LEN)) && (frm_len <= LEN_W'(MAX_LEN));
  wire is_bc   = &frm_da;
  wire any_hit = |hit_vec;

  logic acc_d, ff_d, mf_d;
  always_comb begin
    acc_d = 1'b0;
    ff_d  = 1'b0;
    mf_d  = 1'b0;
    if (len_ok) begin
      if (is_bc) begin
        acc_d = 1'b1;
      end else if (mode_q[M_PROM] || mode_q[M_RALL]) begin
        acc_d = 1'b1;
        ff_d  = 1'b1;
      end else if (mode_q[M_MCAST] && frm_da[0]) begin
        acc_d = 1'b1;
        mf_d  = 1'b1;
      end else begin
        acc_d = any_hit ^ mode_q[M_INV];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_accept    <= 1'b0;
      res_filt_fail <= 1'b0;
      res_mcast     <= 1'b0;
    end else if (frm_valid) begin
      res_accept    <= acc_d;
      res_filt_fail <= ff_d;
      res_mcast     <= mf_d;
    end
  end

  AST_LEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && (frm_len < LEN_W'(MIN_LEN) || frm_len > LEN_W'(MAX_LEN))
    |=> !res_accept && !res_filt_fail && !res_mcast); // R10

  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && len_ok && (frm_da == 48'hFFFF_FFFF_FFFF)
    |=> res_accept && !res_filt_fail && !res_mcast); // R5

  AST_PROMISC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && len_ok && !is_bc && (mode_q[M_PROM] || mode_q[M_RALL])
    |=> res_accept && res_filt_fail); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable({res_accept, res_filt_fail, res_mcast})); // R11

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({res_filt_fail, res_mcast}) <= 1) &&
    (!(res_filt_fail || res_mcast) || res_accept)); // R9

  AST_LOAD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start && (cfg_len != LEN_W'(SETUP_LEN)) |=> !ld_act); // R2
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [11:0] cfg_len = '0;
  logic        cfg_valid = 1'b0;
  logic [7:0]  cfg_byte = '0;
  logic        mode_we = 1'b0;
  logic [3:0]  mode_in = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_da = '0;
  logic [11:0] frm_len = '0;
  logic        res_accept, res_filt_fail, res_mcast;

  rx_addr_filter dut (.*);

  always #2.5 clk = ~clk;

  int total = 0;
  int fails = 0;
  logic [47:0] m_tbl [16];
  logic [3:0]  m_mode = '0;
  logic [2:0]  exp_q [$];
  string       tag_q [$];
  logic [2:0]  last_exp = '0;

  function automatic logic [2:0] model(logic [47:0] da, logic [11:0] len);
    logic hit = 1'b0;
    if (len < 14 || len > 2044) return 3'b000;
    if (da == 48'hFFFF_FFFF_FFFF) return 3'b100;
    if (m_mode[0] || m_mode[1]) return 3'b110;
    if (m_mode[2] && da[0]) return 3'b101;
    for (int i = 0; i < 16; i++) if (m_tbl[i] == da) hit = 1'b1;
    return {hit ^ m_mode[3], 2'b00};
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {acc,ff,mf}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(logic [47:0] da, logic [11:0] len, string tag);
    exp_q.push_back(model(da, len));
    tag_q.push_back(tag);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_da = da;
    frm_len = len;
    @(negedge clk);
    frm_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(logic [3:0] m);
    @(negedge clk);
    mode_we = 1'b1;
    mode_in = m;
    @(negedge clk);
    mode_we = 1'b0;
    m_mode = m;
  endtask

  function automatic logic [7:0] gen(int seed, int i);
    return 8'((seed * 37 + i * 13 + (i >> 4)) & 255);
  endfunction

  task automatic load(int len, int seed);
    int sl[6] = '{0, 1, 4, 5, 8, 9};
    @(negedge clk);
    cfg_start = 1'b1;
    cfg_len = 12'(len);
    @(negedge clk);
    cfg_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      cfg_valid = 1'b1;
      cfg_byte = gen(seed, i);
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    if (len == 192)
      for (int n = 0; n < 16; n++)
        for (int k = 0; k < 6; k++) m_tbl[n][8*k +: 8] = gen(seed, 12*n + sl[k]);
  endtask

  always @(posedge clk) begin
    if (rst_n && frm_valid) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        total++; fails++;
        $display("FAIL R11: unexpected result got %b expected none",
                 {res_accept, res_filt_fail, res_mcast});
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), {res_accept, res_filt_fail, res_mcast}, last_exp);
      end
    end
  end

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [47:0] other, mc, wrong;
    for (int i = 0; i < 16; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {res_accept, res_filt_fail, res_mcast}, 3'b000);
    send(48'h0, 12'd60, "R1 zeroed table matches zero address");
    send(48'h0000_0000_1234, 12'd60, "R1 modes off, unlisted rejected");

    load(192, 5);
    send(m_tbl[0], 12'd64, "R4 entry 0 match");
    send(m_tbl[7], 12'd64, "R4 entry 7 match");
    send(m_tbl[15], 12'd64, "R3 entry 15 match");
    wrong = '0;
    for (int k = 0; k < 6; k++) wrong[8*k +: 8] = gen(5, 36 + k);
    send(wrong, 12'd64, "R3 contiguous bytes rejected");
    send(48'h0000_0000_0000, 12'd64, "R2 old zero entries replaced");
    other = 48'h0000_5A5A_5A5A;
    send(other, 12'd64, "R4 unlisted unicast rejected");

    load(100, 9);
    send(m_tbl[3], 12'd64, "R2 short setup keeps entry 3");
    load(191, 11);
    send(m_tbl[12], 12'd64, "R2 191-byte setup keeps entry 12");

    send(48'hFFFF_FFFF_FFFF, 12'd64, "R5 broadcast accepted");
    send(48'hFFFF_FFFF_FFFF, 12'd10, "R10 short broadcast dropped");
    send(m_tbl[1], 12'd13, "R10 length 13 dropped");
    send(m_tbl[1], 12'd14, "R10 length 14 passes");
    send(m_tbl[1], 12'd2044, "R10 length 2044 passes");
    send(m_tbl[1], 12'd2045, "R10 length 2045 dropped");

    set_mode(4'b0001);
    send(other, 12'd64, "R6 R12 promiscuous accepts unlisted");
    send(48'hFFFF_FFFF_FFFF, 12'd64, "R9 broadcast beats promiscuous");
    set_mode(4'b0010);
    send(other, 12'd64, "R6 R12 receive-all accepts unlisted");

    mc = 48'h0000_0000_0033;
    set_mode(4'b0100);
    send(mc, 12'd64, "R7 multicast passed");
    send(other, 12'd64, "R7 unicast not passed");
    set_mode(4'b0101);
    send(mc, 12'd64, "R9 promiscuous beats multicast");

    set_mode(4'b1000);
    send(m_tbl[4], 12'd64, "R8 inverse rejects match");
    send(other, 12'd64, "R8 inverse accepts unlisted");
    send(48'hFFFF_FFFF_FFFF, 12'd64, "R9 inverse leaves broadcast");
    set_mode(4'b1100);
    send(mc, 12'd64, "R9 inverse leaves multicast");
    send(48'hFFFF_FFFF_FFFF, 12'd5, "R10 drop with all modes");

    set_mode(4'b0000);
    frm_da = 48'hFFFF_FFFF_FFFF;
    frm_len = 12'd64;
    repeat (4) @(negedge clk);
    check("R11 result held without strobe", {res_accept, res_filt_fail, res_mcast}, last_exp);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule